// File: doc/BRIEF.md
# Read Completion Splitter at the Read Completion Boundary

This block sits on the completer side of a transaction layer. It accepts one request descriptor at a time and turns it into completion headers: the request kind, the DW-aligned start address, the Length in DWs, the first and last byte-enable nibbles, the Requester ID, the Tag, the traffic class and the attributes. Memory reads, plain or locked, are cut at naturally aligned Read Completion Boundary (RCB) blocks. The block size is 64 or 128 bytes and a configuration input picks it. Each piece carries the bytes still owed, its own first byte address and the number of DWs it spans. IO and configuration reads give one single-DW data completion. Atomic operations give one data completion. Writes give a status-only completion.

Headers leave on a valid/ready interface, one per accepted handshake, in increasing address order. Payload data, payload-size limits and error status are handled elsewhere. The status field always reads successful completion. Only the offset of the start address inside a 128-byte window changes what the block does, so only the low five DW-address bits enter it.

The control is a three-state machine. ST_IDLE holds `req_ready` high. An accepted memory read moves it to ST_SPLIT; any other accepted kind moves it to ST_SINGLE. ST_SPLIT stays put while headers are taken and still more bytes are owed, and returns to ST_IDLE when the header that carries the remainder is taken. ST_SINGLE returns to ST_IDLE when its only header is taken. A state with a header pending holds it unchanged while `hdr_ready` is low.

Top module: `rcb_cpl_splitter`

## Requirements
- R1: After reset `req_ready` is 1 and `hdr_valid` is 0.
- R2: Lower Address is the low 7 bits of (DW address × 4 + index of the lowest set bit of the first-DW byte enable, 0 when that nibble is zero) for a request's first piece. For every later piece it is the low 7 bits of that piece's first byte address.
- R3: With `rcb_128`=0 the boundary is 64 bytes, and with 1 it is 128 bytes; the value is taken when the request is accepted. The first piece runs up to the next boundary, middle pieces cover whole blocks, the last covers the remainder, and all pieces come in increasing address order. For example, bytes 0x38 to 0x97 at 64 bytes give pieces of 8, 64 and 24 bytes.
- R4: A memory read whose bytes all lie in one boundary block produces exactly one header.
- R5: Byte Count is the number of bytes still owed including the piece's own bytes, taken modulo 4096, so 4096 reads as 0. In the example the Byte Counts are 96, 88 and 24.
- R6: IO read (kind 2) and configuration read (kind 3) produce one data header with Length 1 and Byte Count 4. They are never split.
- R7: The Fmt/Type pairs are as follows. Data completions use Fmt 3'b010 with Type 5'b01010. Locked memory read completions (kind 1) use Fmt 3'b010 with Type 5'b01011. Status-only completions use Fmt 3'b000 with Type 5'b01010. The kind codes are 0 memory read, 1 locked memory read, 2 IO read, 3 config read, 4 IO write, 5 config write, 6 atomic; code 7 is treated as a write.
- R8: The Length of a read piece is the number of DWs its bytes touch after DW alignment, ceil((Lower Address mod 4 + piece bytes) / 4).
- R9: TC, Attr, Requester ID and Tag are copied unchanged from the request. The completer ID input captured at acceptance appears on `hdr_cpl_id`. Status is 3'b000 and BCM is 0.
- R10: Write kinds (4, 5, 7) produce one status-only header with Length 0, Byte Count 4 and Lower Address 0. An atomic request (kind 6) produces one data header with the request's Length field, Byte Count equal to Length × 4 modulo 4096, and Lower Address 0.
- R11: While a header is pending, `req_ready` is low. A header held with `hdr_ready` low keeps all its fields. Exactly one header is consumed per handshake.
- R12: The total byte count of a read depends on its Length. For Length 1 it runs from the lowest to the highest set bit of the first-DW enable, and is 1 when that nibble is zero. For any other Length (0 meaning 1024) it is Length × 4, minus the index of the lowest set first-DW enable bit, minus (3 − index of the highest set last-DW enable bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rcb_128 | input | 1 | Boundary select: 0 = 64 bytes, 1 = 128 bytes |
| cpl_id | input | 16 | This completer's bus/device/function ID |
| req_valid | input | 1 | Request descriptor valid |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 3 | Request kind code (see R7) |
| req_addr_lo | input | 5 | Low DW-address bits inside a 128-byte window |
| req_len | input | 10 | Request Length in DWs, 0 = 1024 |
| req_fbe | input | 4 | First-DW byte enables |
| req_lbe | input | 4 | Last-DW byte enables |
| req_rid | input | 16 | Requester ID |
| req_tag | input | 8 | Tag |
| req_tc | input | 3 | Traffic class |
| req_attr | input | 3 | Attributes |
| hdr_valid | output | 1 | Completion header valid |
| hdr_ready | input | 1 | Downstream takes the header |
| hdr_fmt | output | 3 | Fmt field |
| hdr_type | output | 5 | Type field |
| hdr_tc | output | 3 | Traffic class |
| hdr_attr | output | 3 | Attributes |
| hdr_len | output | 10 | Length in DWs |
| hdr_cpl_id | output | 16 | Completer ID |
| hdr_status | output | 3 | Completion status |
| hdr_bcm | output | 1 | Byte count modified flag |
| hdr_byte_cnt | output | 12 | Bytes still owed |
| hdr_rid | output | 16 | Requester ID |
| hdr_tag | output | 8 | Tag |
| hdr_lower_addr | output | 7 | Lower Address |

## Verification
The hardest case to reach is a Byte Count that wraps. A 1024-DW read owes 4096 bytes, so its first header must show 0 and every later header must show a smaller, non-zero count. This needs a Length field of 0 together with both boundary sizes, which gives 32 and 64 pieces. The stimulus also places unaligned starts just below a boundary, with partial first and last enables, so a first piece can be as short as 2 bytes. Throughout, the downstream ready toggles at random to hold headers mid-sequence.

// File: rtl/rcb_cpl_pkg.sv
package rcb_cpl_pkg;

    localparam int LEN_W      = 10;
    localparam int BC_W       = 12;
    localparam int LA_W       = 7;
    localparam int ADDR_LO_W  = LA_W - 2;
    localparam int TOT_W      = BC_W + 1;
    localparam int PIECE_W    = LA_W + 1;
    localparam int PIECE_DW_W = PIECE_W - 1;
    localparam int TC_W       = 3;
    localparam int ATTR_W     = 3;
    localparam int MAX_BYTES  = 1 << (LEN_W + 2);
    localparam int RCB_SMALL  = 64;
    localparam int RCB_LARGE  = 128;

    localparam logic [2:0] FMT_NODATA  = 3'b000;
    localparam logic [2:0] FMT_DATA    = 3'b010;
    localparam logic [4:0] TYPE_CPL    = 5'b01010;
    localparam logic [4:0] TYPE_CPL_LK = 5'b01011;
    localparam logic [2:0] STATUS_SC   = 3'b000;

    typedef enum logic [2:0] {
        KIND_MEM_RD    = 3'd0,
        KIND_MEM_RD_LK = 3'd1,
        KIND_IO_RD     = 3'd2,
        KIND_CFG_RD    = 3'd3,
        KIND_IO_WR     = 3'd4,
        KIND_CFG_WR    = 3'd5,
        KIND_ATOMIC    = 3'd6,
        KIND_RSVD      = 3'd7
    } req_kind_e;

    typedef enum logic [1:0] {
        CLS_SPLIT,
        CLS_ONE_DW,
        CLS_NODATA,
        CLS_ATOMIC
    } cpl_class_e;

endpackage

// File: rtl/rcb_req_decode.sv
module rcb_req_decode
    import rcb_cpl_pkg::*;
(
    input  logic [2:0]           kind,
    input  logic [LEN_W-1:0]     len,
    input  logic [3:0]           fbe,
    input  logic [3:0]           lbe,
    input  logic [ADDR_LO_W-1:0] addr_lo,
    output cpl_class_e           cls,
    output logic                 locked,
    output logic [TOT_W-1:0]     total_bytes,
    output logic [LA_W-1:0]      start_lo
);

    logic [1:0]       first_off;
    logic [1:0]       first_hi;
    logic [1:0]       tail_drop;
    logic [TOT_W-1:0] len_bytes;

    // byte positions inside the first and last DW
    always_comb begin
        if (fbe[0])      first_off = 2'd0;
        else if (fbe[1]) first_off = 2'd1;
        else if (fbe[2]) first_off = 2'd2;
        else if (fbe[3]) first_off = 2'd3;
        else             first_off = 2'd0;

        if (fbe[3])      first_hi = 2'd3;
        else if (fbe[2]) first_hi = 2'd2;
        else if (fbe[1]) first_hi = 2'd1;
        else             first_hi = 2'd0;

        if (lbe[3])      tail_drop = 2'd0;
        else if (lbe[2]) tail_drop = 2'd1;
        else if (lbe[1]) tail_drop = 2'd2;
        else if (lbe[0]) tail_drop = 2'd3;
        else             tail_drop = 2'd0;
    end

    // total bytes owed by the request (R12)
    always_comb begin
        if (len == '0) len_bytes = TOT_W'(MAX_BYTES);
        else           len_bytes = TOT_W'({len, 2'b00});

        if (len == LEN_W'(1)) begin
            if (fbe == 4'b0000) total_bytes = TOT_W'(1);
            else total_bytes = TOT_W'(first_hi) - TOT_W'(first_off) + TOT_W'(1);
        end else begin
            total_bytes = len_bytes - TOT_W'(first_off) - TOT_W'(tail_drop);
        end
        start_lo = {addr_lo, first_off};
    end

    // completion class per request kind
    always_comb begin
        locked = (kind == KIND_MEM_RD_LK);
        case (kind)
            KIND_MEM_RD, KIND_MEM_RD_LK: cls = CLS_SPLIT;
            KIND_IO_RD, KIND_CFG_RD:     cls = CLS_ONE_DW;
            KIND_ATOMIC:                 cls = CLS_ATOMIC;
            default:                     cls = CLS_NODATA;
        endcase
    end

endmodule

// File: rtl/rcb_piece_calc.sv
module rcb_piece_calc
    import rcb_cpl_pkg::*;
(
    input  logic [LA_W-1:0]       cur_lo,
    input  logic [TOT_W-1:0]      remaining,
    input  logic                  rcb_large,
    output logic [PIECE_W-1:0]    piece_bytes,
    output logic [PIECE_DW_W-1:0] piece_dw,
    output logic                  piece_last
);

    logic [PIECE_W-1:0] offset;
    logic [PIECE_W-1:0] room;
    logic [PIECE_W:0]   span;

    always_comb begin
        if (rcb_large) begin
            offset = PIECE_W'(cur_lo);
            room   = PIECE_W'(RCB_LARGE) - offset;
        end else begin
            offset = PIECE_W'(cur_lo[5:0]);
            room   = PIECE_W'(RCB_SMALL) - offset;
        end

        piece_last  = (remaining <= TOT_W'(room));
        piece_bytes = piece_last ? PIECE_W'(remaining) : room;

        span     = (PIECE_W+1)'(cur_lo[1:0]) + (PIECE_W+1)'(piece_bytes) + (PIECE_W+1)'(3);
        piece_dw = span[PIECE_W:2];
    end

endmodule

// File: rtl/rcb_cpl_splitter.sv
module rcb_cpl_splitter
    import rcb_cpl_pkg::*;
#(
    parameter int ID_W  = 16,
    parameter int TAG_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rcb_128,
    input  logic [ID_W-1:0]      cpl_id,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [2:0]           req_kind,
    input  logic [ADDR_LO_W-1:0] req_addr_lo,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [3:0]           req_fbe,
    input  logic [3:0]           req_lbe,
    input  logic [ID_W-1:0]      req_rid,
    input  logic [TAG_W-1:0]     req_tag,
    input  logic [TC_W-1:0]      req_tc,
    input  logic [ATTR_W-1:0]    req_attr,
    output logic                 hdr_valid,
    input  logic                 hdr_ready,
    output logic [2:0]           hdr_fmt,
    output logic [4:0]           hdr_type,
    output logic [TC_W-1:0]      hdr_tc,
    output logic [ATTR_W-1:0]    hdr_attr,
    output logic [LEN_W-1:0]     hdr_len,
    output logic [ID_W-1:0]      hdr_cpl_id,
    output logic [2:0]           hdr_status,
    output logic                 hdr_bcm,
    output logic [BC_W-1:0]      hdr_byte_cnt,
    output logic [ID_W-1:0]      hdr_rid,
    output logic [TAG_W-1:0]     hdr_tag,
    output logic [LA_W-1:0]      hdr_lower_addr
);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SPLIT,
        ST_SINGLE
    } state_e;

    state_e state_q, state_d;

    // request context
    logic                  rcb_128_q;
    logic                  locked_q;
    logic [LA_W-1:0]       cur_lo_q;
    logic [TOT_W-1:0]      rem_q;
    logic                  sgl_data_q;
    logic [LEN_W-1:0]      sgl_len_q;
    logic [BC_W-1:0]       sgl_bc_q;
    logic [LA_W-1:0]       sgl_la_q;
    logic [ID_W-1:0]       rid_q;
    logic [ID_W-1:0]       cid_q;
    logic [TAG_W-1:0]      tag_q;
    logic [TC_W-1:0]       tc_q;
    logic [ATTR_W-1:0]     attr_q;

    // decoder outputs
    cpl_class_e            dec_cls;
    logic                  dec_locked;
    logic [TOT_W-1:0]      dec_total;
    logic [LA_W-1:0]       dec_start_lo;

    // piece calculator outputs
    logic [PIECE_W-1:0]    piece_bytes;
    logic [PIECE_DW_W-1:0] piece_dw;
    logic                  piece_last;

    logic                  accept;
    logic                  advance;

    rcb_req_decode i_decode (
        .kind        (req_kind),
        .len         (req_len),
        .fbe         (req_fbe),
        .lbe         (req_lbe),
        .addr_lo     (req_addr_lo),
        .cls         (dec_cls),
        .locked      (dec_locked),
        .total_bytes (dec_total),
        .start_lo    (dec_start_lo)
    );

    rcb_piece_calc i_piece (
        .cur_lo      (cur_lo_q),
        .remaining   (rem_q),
        .rcb_large   (rcb_128_q),
        .piece_bytes (piece_bytes),
        .piece_dw    (piece_dw),
        .piece_last  (piece_last)
    );

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign advance = (state_q == ST_SPLIT) && hdr_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (dec_cls == CLS_SPLIT) state_d = ST_SPLIT;
                    else                      state_d = ST_SINGLE;
                end
            end
            ST_SPLIT: begin
                if (hdr_ready && piece_last) state_d = ST_IDLE;
            end
            ST_SINGLE: begin
                if (hdr_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // context capture on accept, advance on each split handshake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcb_128_q  <= 1'b0;
            locked_q   <= 1'b0;
            cur_lo_q   <= '0;
            rem_q      <= '0;
            sgl_data_q <= 1'b0;
            sgl_len_q  <= '0;
            sgl_bc_q   <= '0;
            sgl_la_q   <= '0;
            rid_q      <= '0;
            cid_q      <= '0;
            tag_q      <= '0;
            tc_q       <= '0;
            attr_q     <= '0;
        end else if (accept) begin
            rcb_128_q <= rcb_128;
            locked_q  <= dec_locked;
            cur_lo_q  <= dec_start_lo;
            rem_q     <= dec_total;
            rid_q     <= req_rid;
            cid_q     <= cpl_id;
            tag_q     <= req_tag;
            tc_q      <= req_tc;
            attr_q    <= req_attr;
            unique case (dec_cls)
                CLS_ONE_DW: begin
                    sgl_data_q <= 1'b1;
                    sgl_len_q  <= LEN_W'(1);
                    sgl_bc_q   <= BC_W'(4);
                    sgl_la_q   <= dec_start_lo;
                end
                CLS_ATOMIC: begin
                    sgl_data_q <= 1'b1;
                    sgl_len_q  <= req_len;
                    sgl_bc_q   <= BC_W'({req_len, 2'b00});
                    sgl_la_q   <= '0;
                end
                CLS_NODATA: begin
                    sgl_data_q <= 1'b0;
                    sgl_len_q  <= '0;
                    sgl_bc_q   <= BC_W'(4);
                    sgl_la_q   <= '0;
                end
                default: begin
                    sgl_data_q <= 1'b1;
                    sgl_len_q  <= '0;
                    sgl_bc_q   <= '0;
                    sgl_la_q   <= '0;
                end
            endcase
        end else if (advance) begin
            cur_lo_q <= cur_lo_q + LA_W'(piece_bytes);
            rem_q    <= rem_q - TOT_W'(piece_bytes);
        end
    end

    // output decode
    always_comb begin
        req_ready      = 1'b0;
        hdr_valid      = 1'b0;
        hdr_fmt        = FMT_NODATA;
        hdr_type       = TYPE_CPL;
        hdr_len        = '0;
        hdr_byte_cnt   = '0;
        hdr_lower_addr = '0;
        hdr_tc         = tc_q;
        hdr_attr       = attr_q;
        hdr_rid        = rid_q;
        hdr_tag        = tag_q;
        hdr_cpl_id     = cid_q;
        hdr_status     = STATUS_SC;
        hdr_bcm        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_SPLIT: begin
                hdr_valid      = 1'b1;
                hdr_fmt        = FMT_DATA;
                hdr_type       = locked_q ? TYPE_CPL_LK : TYPE_CPL;
                hdr_len        = LEN_W'(piece_dw);
                hdr_byte_cnt   = rem_q[BC_W-1:0];
                hdr_lower_addr = cur_lo_q;
            end
            ST_SINGLE: begin
                hdr_valid      = 1'b1;
                hdr_fmt        = sgl_data_q ? FMT_DATA : FMT_NODATA;
                hdr_len        = sgl_len_q;
                hdr_byte_cnt   = sgl_bc_q;
                hdr_lower_addr = sgl_la_q;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rcb_cpl_splitter_chk.sv
module rcb_cpl_splitter_chk
    import rcb_cpl_pkg::*;
#(
    parameter int ID_W  = 16,
    parameter int TAG_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              hdr_valid,
    input logic              hdr_ready,
    input logic [2:0]        hdr_fmt,
    input logic [LEN_W-1:0]  hdr_len,
    input logic [BC_W-1:0]   hdr_byte_cnt,
    input logic [LA_W-1:0]   hdr_lower_addr,
    input logic [ID_W-1:0]   hdr_rid,
    input logic [TAG_W-1:0]  hdr_tag,
    input logic              rcb_sel
);

    // R11: a held header keeps every field
    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_fmt) && $stable(hdr_len)
            && $stable(hdr_byte_cnt) && $stable(hdr_lower_addr)
            && $stable(hdr_rid) && $stable(hdr_tag));

    // R11: no new request while a header is pending
    p_busy_no_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> !req_ready);

    // R3: a piece following a taken piece starts on a boundary
    p_cont_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_ready |=> !hdr_valid
            || (rcb_sel ? (hdr_lower_addr == '0) : (hdr_lower_addr[5:0] == 6'd0)));

    // R5: the byte count owed shrinks from piece to piece
    p_bc_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_ready && (hdr_byte_cnt != '0) |=> !hdr_valid
            || (hdr_byte_cnt < $past(hdr_byte_cnt)));

    // R10: status-only headers carry no length and no lower address
    p_nodata_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && (hdr_fmt == FMT_NODATA) |-> (hdr_len == '0)
            && (hdr_lower_addr == '0) && (hdr_byte_cnt == BC_W'(4)));

endmodule

bind rcb_cpl_splitter rcb_cpl_splitter_chk #(.ID_W(ID_W), .TAG_W(TAG_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_ready      (req_ready),
    .hdr_valid      (hdr_valid),
    .hdr_ready      (hdr_ready),
    .hdr_fmt        (hdr_fmt),
    .hdr_len        (hdr_len),
    .hdr_byte_cnt   (hdr_byte_cnt),
    .hdr_lower_addr (hdr_lower_addr),
    .hdr_rid        (hdr_rid),
    .hdr_tag        (hdr_tag),
    .rcb_sel        (rcb_128_q)
);

// File: tb/test_rcb_cpl_splitter.sv
`timescale 1ns/1ps
module test_rcb_cpl_splitter;
    import rcb_cpl_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rcb_128 = 1'b0;
    logic [15:0] cpl_id = 16'h0A18;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic [4:0]  req_addr_lo = '0;
    logic [9:0]  req_len = '0;
    logic [3:0]  req_fbe = '0;
    logic [3:0]  req_lbe = '0;
    logic [15:0] req_rid = '0;
    logic [7:0]  req_tag = '0;
    logic [2:0]  req_tc = '0;
    logic [2:0]  req_attr = '0;
    logic        hdr_valid;
    logic        hdr_ready;
    logic [2:0]  hdr_fmt;
    logic [4:0]  hdr_type;
    logic [2:0]  hdr_tc;
    logic [2:0]  hdr_attr;
    logic [9:0]  hdr_len;
    logic [15:0] hdr_cpl_id;
    logic [2:0]  hdr_status;
    logic        hdr_bcm;
    logic [11:0] hdr_byte_cnt;
    logic [15:0] hdr_rid;
    logic [7:0]  hdr_tag;
    logic [6:0]  hdr_lower_addr;

    always #2.5 clk = ~clk;

    rcb_cpl_splitter i_rcb_cpl_splitter (.*);

    typedef struct {
        int fmt; int typ; int len; int bc; int la;
    } exp_t;

    exp_t q[$];
    int   e_tag, e_rid, e_tc, e_attr, e_cid;
    int   n_tests = 0;
    int   n_fail = 0;
    int   popped = 0;
    bit   finished = 0;

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // behavioural reference: list of headers for one request
    function automatic void model(input int kind, input int alo, input int len,
                                  input int fbe, input int lbe, input int big);
        int fo, hi, drop, total, b, rem, rcb, room, n, leff;
        exp_t e;
        fo = 0; hi = 0; drop = 0;
        for (int i = 3; i >= 0; i--) if (fbe[i]) fo = i;
        for (int i = 0; i < 4; i++) if (fbe[i]) hi = i;
        if (lbe != 0) begin
            for (int i = 0; i < 4; i++) if (lbe[i]) drop = 3 - i;
        end
        leff = (len == 0) ? 1024 : len;
        if (leff == 1) total = (fbe == 0) ? 1 : hi - fo + 1;
        else           total = leff * 4 - fo - drop;
        b = alo * 4 + fo;
        case (kind)
            0, 1: begin
                rcb = big ? 128 : 64;
                rem = total;
                while (rem > 0) begin
                    room = rcb - (b % rcb);
                    n = (rem < room) ? rem : room;
                    e.fmt = 2; e.typ = (kind == 1) ? 11 : 10;
                    e.len = ((b % 4) + n + 3) / 4;
                    e.bc = rem % 4096; e.la = b % 128;
                    q.push_back(e);
                    b += n; rem -= n;
                end
            end
            2, 3: begin
                e.fmt = 2; e.typ = 10; e.len = 1; e.bc = 4; e.la = b % 128;
                q.push_back(e);
            end
            6: begin
                e.fmt = 2; e.typ = 10; e.len = len; e.bc = (leff * 4) % 4096; e.la = 0;
                q.push_back(e);
            end
            default: begin
                e.fmt = 0; e.typ = 10; e.len = 0; e.bc = 4; e.la = 0;
                q.push_back(e);
            end
        endcase
    endfunction

    // monitor: drives downstream ready and compares every taken header
    always @(negedge clk) begin
        if (!rst_n || finished) begin
            hdr_ready = 1'b0;
        end else begin
            hdr_ready = (($urandom % 4) != 0);
            if (hdr_valid) begin
                chk("R11", "req_ready while header pending", int'(req_ready), 0);
                if (hdr_ready) begin
                    if (q.size() == 0) begin
                        chk("R11", "header with nothing owed", 1, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        popped++;
                        chk("R7", "fmt/type", int'(hdr_fmt) * 32 + int'(hdr_type), e.fmt * 32 + e.typ);
                        chk("R8", "length", int'(hdr_len), e.len);
                        chk("R5", "byte count", int'(hdr_byte_cnt), e.bc);
                        chk("R2", "lower address", int'(hdr_lower_addr), e.la);
                        chk("R9", "tag", int'(hdr_tag), e_tag);
                        chk("R9", "requester id", int'(hdr_rid), e_rid);
                        chk("R9", "tc/attr", int'(hdr_tc) * 8 + int'(hdr_attr), e_tc * 8 + e_attr);
                        chk("R9", "completer id", int'(hdr_cpl_id), e_cid);
                        chk("R9", "status/bcm", int'(hdr_status) * 2 + int'(hdr_bcm), 0);
                    end
                end
            end
        end
    end

    task automatic send(input int kind, input int alo, input int len, input int fbe,
                        input int lbe, input int big, input int n_exp, input string rq);
        @(negedge clk);
        rcb_128     = big[0];
        req_kind    = kind[2:0];
        req_addr_lo = alo[4:0];
        req_len     = len[9:0];
        req_fbe     = fbe[3:0];
        req_lbe     = lbe[3:0];
        req_rid     = 16'($urandom);
        req_tag     = 8'($urandom);
        req_tc      = 3'($urandom);
        req_attr    = 3'($urandom);
        req_valid   = 1'b1;
        while (!req_ready) @(negedge clk);
        e_tag = req_tag; e_rid = req_rid; e_tc = req_tc; e_attr = req_attr; e_cid = cpl_id;
        popped = 0;
        model(kind, alo, len, fbe, lbe, big);
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        chk(rq, "headers still owed", q.size(), 0);
        if (n_exp >= 0) chk(rq, "header count", popped, n_exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready after reset", int'(req_ready), 1);
        chk("R1", "hdr_valid after reset", int'(hdr_valid), 0);

        // R3: worked example, bytes 0x38..0x97
        send(0, 5'h0E, 24, 4'hF, 4'hF, 0, 3, "R3");
        send(0, 5'h0E, 24, 4'hF, 4'hF, 1, 2, "R3");
        // R4: span inside one block
        send(0, 5'h10, 4, 4'hF, 4'hF, 0, 1, "R4");
        send(0, 5'h00, 32, 4'hF, 4'hF, 1, 1, "R4");
        // R2 / R12: partial enables, 2-byte first piece
        send(0, 5'h0F, 3, 4'b1100, 4'b0011, 0, 2, "R2");
        send(0, 5'h05, 1, 4'b0110, 4'b0000, 0, 1, "R12");
        send(0, 5'h07, 1, 4'b0000, 4'b0000, 1, 1, "R12");
        // R5: 4096-byte reads, wrapping byte count
        send(0, 5'h00, 0, 4'hF, 4'hF, 1, 32, "R5");
        send(0, 5'h00, 0, 4'hF, 4'hF, 0, 64, "R5");
        // R6: IO and configuration reads
        send(2, 5'h03, 1, 4'b1000, 4'b0000, 0, 1, "R6");
        send(3, 5'h1F, 1, 4'hF, 4'b0000, 1, 1, "R6");
        // R10: writes and atomic
        send(4, 5'h09, 1, 4'hF, 4'b0000, 0, 1, "R10");
        send(5, 5'h02, 1, 4'b0011, 4'b0000, 0, 1, "R10");
        send(6, 5'h04, 2, 4'hF, 4'hF, 0, 1, "R10");
        // R7: locked read
        send(1, 5'h0E, 24, 4'hF, 4'hF, 0, 3, "R7");

        // R11: mixed random traffic under backpressure
        for (int k = 0; k < 300; k++) begin
            int kind, len, fbe, lbe;
            kind = $urandom % 7;
            len  = ($urandom % 8 == 0) ? 0 : 1 + $urandom % 40;
            if (kind >= 2) len = (kind == 6) ? 1 + $urandom % 4 : 1;
            fbe  = $urandom % 16;
            lbe  = (len == 1) ? 0 : 1 + $urandom % 15;
            if (len != 1 && fbe == 0) fbe = 4'hF;
            send(kind, $urandom % 32, len, fbe, lbe, $urandom % 2, -1, "R11");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule